// File: doc/BRIEF.md
# Transmit Packet Framer

This block turns bytes written into its own transmit FIFO into a framed outgoing byte stream. After a start strobe it sends a run of preamble bytes. When the FIFO holds data it sends a sync pattern, then the packet bytes drawn from the FIFO, and optionally a two-byte checksum. The output is a byte stream with a valid/ready handshake, and it feeds the serializer or modulator that follows.

Packet length is either fixed by configuration or taken from the first FIFO byte. If the FIFO runs dry in the middle of a packet, the framer stops. It raises a sticky underflow flag and ignores further writes and start strobes as a way to resume. Only the flush strobe clears this state. The flush also empties the FIFO and returns the framer to idle.

Top module: `tx_framer`

## Requirements
- R1: After `tx_start` in idle, the framer sends preamble bytes of value 0xAA. It sends at least `cfg_pre_len` of them, and a setting of 0 sends exactly one.
- R2: The sync pattern follows the preamble. With `cfg_long_sync`=0 it is `cfg_sync[15:8]` then `cfg_sync[7:0]`. With `cfg_long_sync`=1 those two bytes are sent twice. The sync pattern is never sent while the FIFO is empty.
- R3: With `cfg_var_len`=1, the first FIFO byte is sent as the length value L, followed by exactly L more FIFO bytes.
- R4: With `cfg_var_len`=0, exactly `cfg_fixed_len` FIFO bytes (1 to 255) are sent after the sync pattern.
- R5: If the FIFO is empty once the configured preamble count is reached, 0xAA bytes keep coming until a byte is written. The sync pattern then follows.
- R6: With `cfg_crc_en`=1, two bytes follow the packet, high byte first. They are the CRC-16 over all packet bytes drawn from the FIFO, using polynomial 0x8005, initial value 0xFFFF and no reflection, with each byte fed in MSB first.
- R7: If the FIFO is empty while packet bytes remain, `underflow` goes high and `out_valid` stays low.
- R8: While `underflow` is high, FIFO writes and `tx_start` produce no output, and `underflow` stays high.
- R9: `flush` empties the FIFO, clears `underflow` and returns the framer to idle (`busy`=0) on the next clock.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold until the byte is accepted.
- R11: `fifo_full` is high when the FIFO holds DEPTH bytes. A write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| tx_start | input | 1 | Start a packet when idle |
| flush | input | 1 | Empty FIFO, clear underflow, go idle |
| cfg_pre_len | input | 8 | Minimum preamble byte count |
| cfg_long_sync | input | 1 | Send the sync word twice |
| cfg_sync | input | 16 | Sync word, high byte sent first |
| cfg_var_len | input | 1 | First FIFO byte gives the length |
| cfg_fixed_len | input | 8 | Packet length in fixed mode |
| cfg_crc_en | input | 1 | Append CRC-16 |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| busy | output | 1 | Framer is not idle |
| underflow | output | 1 | Sticky FIFO underflow |

## Verification
A corrupt FSM state or count shows up within the same packet. It appears as a wrong number of preamble, sync or payload bytes, or as a checksum that disagrees with one the bench computes from the bytes it wrote. A FIFO pointer fault shows as stale or skipped payload bytes, including leftovers that a flush failed to remove. Those leftovers appear on the first packet after the flush. An underflow latch that leaks shows as bytes leaving the block within a few cycles of a write or start that should have been ignored.

// File: rtl/tx_framer.sv
module tx_framer #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic        fifo_full,
  input  logic        tx_start,
  input  logic        flush,
  input  logic [7:0]  cfg_pre_len,
  input  logic        cfg_long_sync,
  input  logic [15:0] cfg_sync,
  input  logic        cfg_var_len,
  input  logic [7:0]  cfg_fixed_len,
  input  logic        cfg_crc_en,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        busy,
  output logic        underflow
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SYNC, S_PAY, S_CRC, S_UFL} st_t;

  st_t          state;
  logic [7:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]  cnt;
  logic [7:0]   pre_cnt, rem, nrem;
  logic [1:0]   idx;
  logic         first;
  logic [15:0]  crc;
  logic         empty, push, pop, xfer;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  assign empty     = (cnt == 0);
  assign fifo_full = (cnt == (AW+1)'(DEPTH));
  assign push      = wr_en && !fifo_full && !flush;
  assign busy      = (state != S_IDLE);
  assign underflow = (state == S_UFL);
  assign xfer      = out_valid && out_ready;
  assign pop       = (state == S_PAY) && xfer && !flush;

  always_comb begin
    out_data  = 8'h00;
    out_valid = 1'b0;
    case (state)
      S_PRE:  begin out_data = 8'hAA; out_valid = 1'b1; end
      S_SYNC: begin out_data = idx[0] ? cfg_sync[7:0] : cfg_sync[15:8]; out_valid = 1'b1; end
      S_PAY:  begin out_data = mem[rp]; out_valid = !empty; end
      S_CRC:  begin out_data = idx[0] ? crc[7:0] : crc[15:8]; out_valid = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (first) nrem = cfg_var_len ? out_data : cfg_fixed_len - 8'd1;
    else       nrem = rem - 8'd1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      state   <= S_IDLE;
      pre_cnt <= '0;
      idx     <= '0;
      rem     <= '0;
      first   <= 1'b0;
      crc     <= 16'hFFFF;
    end else begin
      case (state)
        S_IDLE: if (tx_start) begin
          state   <= S_PRE;
          pre_cnt <= '0;
        end
        S_PRE: if (xfer) begin
          if (pre_cnt < cfg_pre_len) pre_cnt <= pre_cnt + 8'd1;
          if ({1'b0, pre_cnt} + 9'd1 >= {1'b0, cfg_pre_len} && !empty) begin
            state <= S_SYNC;
            idx   <= '0;
          end
        end
        S_SYNC: if (xfer) begin
          if (idx == (cfg_long_sync ? 2'd3 : 2'd1)) begin
            state <= S_PAY;
            first <= 1'b1;
            crc   <= 16'hFFFF;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_PAY: begin
          if (empty) begin
            state <= S_UFL;
          end else if (xfer) begin
            first <= 1'b0;
            rem   <= nrem;
            crc   <= crc_step(crc, out_data);
            if (nrem == 8'd0) begin
              state <= cfg_crc_en ? S_CRC : S_IDLE;
              idx   <= '0;
            end
          end
        end
        S_CRC: if (xfer) begin
          if (idx[0]) state <= S_IDLE;
          else        idx   <= 2'd1;
        end
        default: state <= S_UFL;
      endcase
    end
  end

  p_sync_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state == S_SYNC)) |-> (cnt != 0));

  p_ufl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> !out_valid);

  p_ufl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !flush) |=> underflow);

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!underflow && !busy && empty));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop && !flush) |=> fifo_full);
endmodule

// File: tb/tx_framer_tb.sv
module tx_framer_tb;
  localparam int DEPTH = 16;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, tx_start = 0, flush = 0;
  logic [7:0]  wr_data = 0;
  logic        fifo_full;
  logic [7:0]  cfg_pre_len = 1;
  logic        cfg_long_sync = 0, cfg_var_len = 0, cfg_crc_en = 0;
  logic [15:0] cfg_sync = 16'hD391;
  logic [7:0]  cfg_fixed_len = 1;
  logic [7:0]  out_data;
  logic        out_valid, out_ready = 1, busy, underflow;
  logic        bp = 0;
  logic [7:0]  lfsr = 8'h5B;

  int total = 0, bad = 0;
  logic [7:0] cap [64];
  int cap_n = 0;
  logic [7:0] expq [64];
  int exp_n = 0;

  tx_framer #(.DEPTH(DEPTH)) u_dut (.*);

  always #2.5 clk = ~clk;

  always @(negedge clk)
    if (out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_data;
      cap_n++;
    end

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp ? lfsr[0] : 1'b1;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] ref_crc(input int n, input int from);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {expq[from+k], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic start();
    cap_n = 0; tx_start = 1; tick(); tx_start = 0;
  endtask

  task automatic do_flush();
    flush = 1; tick(); flush = 0;
  endtask

  task automatic pe(input logic [7:0] d);
    expq[exp_n] = d; exp_n++;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) tick();
    tick(2);
  endtask

  task automatic cmp_seq(input string req);
    check(cap_n == exp_n, req, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      check(cap[i] == expq[i], req, cap[i], expq[i]);
  endtask

  task automatic t_reset();
    check(!out_valid && !busy && !underflow && !fifo_full, "R9 reset", {out_valid, busy, underflow, fifo_full}, 0);
  endtask

  task automatic t_fixed_crc();
    logic [15:0] c;
    cfg_pre_len = 3; cfg_long_sync = 0; cfg_var_len = 0; cfg_fixed_len = 4; cfg_crc_en = 1;
    exp_n = 0;
    pe(8'hAA); pe(8'hAA); pe(8'hAA); pe(8'hD3); pe(8'h91);
    pe(8'h11); pe(8'h22); pe(8'h33); pe(8'h44);
    c = ref_crc(4, 5);
    pe(c[15:8]); pe(c[7:0]);
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    start(); wait_idle();
    cmp_seq("R1 R2 R4 R6 fixed");
  endtask

  task automatic t_var_long();
    logic [15:0] c;
    cfg_pre_len = 2; cfg_long_sync = 1; cfg_sync = 16'h1234; cfg_var_len = 1; cfg_crc_en = 1;
    exp_n = 0;
    pe(8'hAA); pe(8'hAA); pe(8'h12); pe(8'h34); pe(8'h12); pe(8'h34);
    pe(8'h03); pe(8'hA1); pe(8'hB2); pe(8'hC3);
    c = ref_crc(4, 6);
    pe(c[15:8]); pe(c[7:0]);
    wr(8'h03); wr(8'hA1); wr(8'hB2); wr(8'hC3); wr(8'h77);
    start(); wait_idle();
    cmp_seq("R3 R2 R6 var/long");
    check(!underflow, "R3 no underflow", underflow, 0);
    do_flush();
  endtask

  task automatic t_stall();
    int npre;
    cfg_pre_len = 2; cfg_long_sync = 0; cfg_sync = 16'hD391; cfg_var_len = 0;
    cfg_fixed_len = 2; cfg_crc_en = 0;
    start(); tick(20);
    check(cap_n >= 15, "R5 preamble continues", cap_n, 15);
    npre = 0;
    for (int i = 0; i < cap_n; i++) if (cap[i] == 8'hAA) npre++;
    check(npre == cap_n, "R5 only preamble while empty", npre, cap_n);
    wr(8'h5E); wr(8'h6F);
    wait_idle();
    npre = 0;
    while (npre < cap_n && cap[npre] == 8'hAA) npre++;
    check(cap_n == npre + 4, "R5 tail length", cap_n, npre + 4);
    check(cap[npre] == 8'hD3 && cap[npre+1] == 8'h91, "R2 sync after stall", {cap[npre], cap[npre+1]}, 16'hD391);
    check(cap[npre+2] == 8'h5E && cap[npre+3] == 8'h6F, "R5 data after stall", {cap[npre+2], cap[npre+3]}, 16'h5E6F);
  endtask

  task automatic t_underflow();
    int n0;
    cfg_pre_len = 1; cfg_var_len = 0; cfg_fixed_len = 5; cfg_crc_en = 0;
    exp_n = 0;
    pe(8'hAA); pe(8'hD3); pe(8'h91); pe(8'h01); pe(8'h02);
    wr(8'h01); wr(8'h02);
    start(); tick(15);
    cmp_seq("R7 bytes before underflow");
    check(underflow && !out_valid, "R7 underflow", {underflow, out_valid}, 2);
    n0 = cap_n;
    wr(8'h03); wr(8'h04); wr(8'h05);
    tx_start = 1; tick(); tx_start = 0;
    tick(15);
    check(cap_n == n0, "R8 no restart", cap_n, n0);
    check(underflow, "R8 sticky", underflow, 1);
    do_flush();
    check(!underflow && !busy, "R9 flush clears", {underflow, busy}, 0);
    cfg_fixed_len = 1;
    exp_n = 0;
    pe(8'hAA); pe(8'hD3); pe(8'h91); pe(8'h5C);
    wr(8'h5C);
    start(); wait_idle();
    cmp_seq("R9 fifo emptied");
  endtask

  task automatic t_backpressure();
    logic [15:0] c;
    cfg_pre_len = 0; cfg_fixed_len = 3; cfg_crc_en = 1;
    exp_n = 0;
    pe(8'hAA); pe(8'hD3); pe(8'h91); pe(8'hF0); pe(8'h0F); pe(8'h99);
    c = ref_crc(3, 3);
    pe(c[15:8]); pe(c[7:0]);
    wr(8'hF0); wr(8'h0F); wr(8'h99);
    bp = 1;
    start(); wait_idle();
    bp = 0; tick(2);
    cmp_seq("R10 R1 backpressure");
  endtask

  task automatic t_full();
    cfg_pre_len = 1; cfg_fixed_len = 8'(DEPTH + 1); cfg_crc_en = 0;
    exp_n = 0;
    pe(8'hAA); pe(8'hD3); pe(8'h91);
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'(i * 3 + 1));
      pe(8'(i * 3 + 1));
    end
    check(fifo_full, "R11 full flag", fifo_full, 1);
    wr(8'hEE);
    start(); tick(60);
    cmp_seq("R11 write dropped");
    check(underflow, "R11 R7 underflow after drop", underflow, 1);
    do_flush();
    check(!fifo_full, "R11 full cleared", fifo_full, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1; tick();
    t_reset();
    t_fixed_crc();
    t_var_long();
    t_stall();
    t_underflow();
    t_backpressure();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule